// File: doc/BRIEF.md
# Continuous-Read ADC Frame Reader

This block sits on the host side of an eight-channel, 24-bit delta-sigma converter that streams conversions without being asked. When the converter's active-low data-ready line falls while the reader is idle, the reader asserts chip select and acts as the serial clock master. It drives a burst of exactly 216 serial clock periods and shifts in the converter's output. It then splits the burst into a 24-bit status word and eight channel samples.

The status word carries a fixed 4-bit header, positive-side and negative-side lead-off flags (one bit per channel each) and four general-purpose pin bits. Each 24-bit sample is two's complement and is widened to 32 bits by sign extension. All parsed fields appear together with a single-cycle `frame_valid` strobe. The parsed outputs form a flow-only stream: the converter cannot be paused, so there is no ready input and no back-pressure. A consumer that misses the strobe can still read the held outputs until the next frame replaces them. A header mismatch raises `hdr_err`, but the frame is still delivered. A data-ready fall that arrives while a burst is in progress is counted as an overrun and is otherwise ignored.

Top module: `adc_frame_reader`

## Requirements
- R1: A synchronized falling edge of `drdy_n` while idle drives `cs_n` low. The reader then produces exactly 216 `sclk` periods, and `cs_n` returns high at the system clock edge that samples the last bit.
- R2: `sclk` is low whenever `cs_n` is high. Each `sclk` half-period lasts `sclk_half` system clocks, and a value of 0 is treated as 1. As a result, `cs_n` stays low for exactly 432 × max(`sclk_half`,1) system clocks per frame.
- R3: `miso` is sampled on each falling edge of `sclk`, most significant bit first. Frame bits 215..212 form the header, 211..204 form `lead_p` (bit 211 → `lead_p[7]`), 203..196 form `lead_n`, and 195..192 form `gpio`.
- R4: `hdr_err` is 1 when the header differs from 4'b1100 and 0 otherwise. `frame_valid` is issued in both cases.
- R5: Channel k (1..8) comes from frame bits [191−24(k−1) −: 24] with the most significant byte first. It is sign-extended from bit 23 into bits 31:24 and presented at `samples[32(k−1) +: 32]`.
- R6: A falling edge of `drdy_n` during a frame does not restart or lengthen it. It increments `overrun_cnt` by one, and the counter saturates at all ones.
- R7: `frame_valid` is high for exactly one system clock per frame. All parsed outputs change in that cycle and hold their values until the next frame.
- R8: After reset, `cs_n`=1, `sclk`=0, `frame_valid`=0, `hdr_err`=0 and `overrun_cnt`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_half | input | 8 | Serial clock half-period in system clocks (0 acts as 1) |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| frame_valid | output | 1 | One-cycle strobe: new frame fields present |
| hdr_err | output | 1 | Header of the last frame was not 1100 |
| lead_p | output | 8 | Positive-input lead-off flags |
| lead_n | output | 8 | Negative-input lead-off flags |
| gpio | output | 4 | General-purpose pin bits from the status word |
| samples | output | 256 | Eight sign-extended 32-bit samples, channel 1 in the low word |
| overrun_cnt | output | 8 | Saturating count of data-ready falls seen mid-frame |

## Verification
The assertions check the following on every cycle: the serial clock rests low with chip select high, a frame ends only when chip select has been low, the bit counter stays in range, the strobe never lasts two cycles, sign bits always replicate into the upper byte, and the overrun count moves only while a burst is active. The bench's scenarios are the only place to show several things. These are the mapping of serial bit positions onto status fields and channel words, the exact burst length at several divide ratios, header-error reporting on a corrupted frame, and the extreme codes 0x800000 and 0xFFFFFF becoming negative 32-bit values. The scenarios also show that a mid-frame data-ready fall leaves the current frame intact.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  localparam int HDR_W = 4;
  localparam logic [HDR_W-1:0] HDR_EXPECT = 4'b1100;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/afr_drdy_sync.sv
module afr_drdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_n,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], drdy_n};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];

  // R1: one start request per falling edge
  p_single_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/afr_shift_engine.sv
module afr_shift_engine
  import adc_frame_pkg::*;
#(
  parameter int FRAME_W = 216,
  parameter int DIV_W   = 8,
  parameter int OVR_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DIV_W-1:0]   sclk_half,
  input  logic               miso,
  output logic               sclk,
  output logic               cs_n,
  output logic [FRAME_W-1:0] frame,
  output logic               done,
  output logic [OVR_W-1:0]   ovr_cnt
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  eng_state_e         st_q;
  logic [DIV_W-1:0]   half_q;
  logic [DIV_W-1:0]   div_q;
  logic [CNT_W-1:0]   bit_q;
  logic               tick;
  logic [DIV_W-1:0]   half_eff;

  assign half_eff = (sclk_half == '0) ? DIV_W'(1) : sclk_half;
  assign tick     = (div_q == half_q - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      half_q <= DIV_W'(1);
      div_q  <= '0;
      bit_q  <= '0;
      sclk   <= 1'b0;
      cs_n   <= 1'b1;
      frame  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ENG_IDLE: begin
          sclk <= 1'b0;
          if (start) begin
            st_q   <= ENG_RUN;
            cs_n   <= 1'b0;
            half_q <= half_eff;
            div_q  <= '0;
            bit_q  <= '0;
          end
        end
        ENG_RUN: begin
          if (tick) begin
            div_q <= '0;
            sclk  <= ~sclk;
            if (sclk) begin
              frame <= {frame[FRAME_W-2:0], miso};
              if (bit_q == LAST_BIT) begin
                st_q <= ENG_IDLE;
                cs_n <= 1'b1;
                done <= 1'b1;
              end else begin
                bit_q <= bit_q + CNT_W'(1);
              end
            end
          end else begin
            div_q <= div_q + DIV_W'(1);
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_cnt <= '0;
    end else if (start && st_q == ENG_RUN && ovr_cnt != '1) begin
      ovr_cnt <= ovr_cnt + OVR_W'(1);
    end
  end

  // R2: serial clock rests low outside a frame
  p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  // R1: bit counter never passes the last frame bit
  p_bit_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= LAST_BIT);
  // R1: completion only closes a frame that had chip select low
  p_done_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n && $past(!cs_n));
  // R6: overrun count moves only during an active burst
  p_ovr_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovr_cnt) |-> $past(!cs_n));
endmodule

// File: rtl/afr_frame_parser.sv
module afr_frame_parser
  import adc_frame_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int SMP_W  = 24,
  parameter int OUT_W  = 32,
  parameter int GPIO_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        done,
  input  logic [HDR_W+2*NCH+GPIO_W+NCH*SMP_W-1:0] frame,
  output logic                        frame_valid,
  output logic                        hdr_err,
  output logic [NCH-1:0]              lead_p,
  output logic [NCH-1:0]              lead_n,
  output logic [GPIO_W-1:0]           gpio,
  output logic [NCH*OUT_W-1:0]        samples
);
  localparam int STAT_W  = HDR_W + 2 * NCH + GPIO_W;
  localparam int DATA_W  = NCH * SMP_W;
  localparam int FRAME_W = STAT_W + DATA_W;
  localparam int EXT_W   = OUT_W - SMP_W;

  logic [STAT_W-1:0] stat_w;
  assign stat_w = frame[FRAME_W-1 -: STAT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_valid <= 1'b0;
      hdr_err     <= 1'b0;
      lead_p      <= '0;
      lead_n      <= '0;
      gpio        <= '0;
    end else begin
      frame_valid <= done;
      if (done) begin
        hdr_err <= (stat_w[STAT_W-1 -: HDR_W] != HDR_EXPECT);
        lead_p  <= stat_w[STAT_W-HDR_W-1 -: NCH];
        lead_n  <= stat_w[STAT_W-HDR_W-NCH-1 -: NCH];
        gpio    <= stat_w[GPIO_W-1:0];
      end
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [SMP_W-1:0] raw;
    assign raw = frame[DATA_W-1-k*SMP_W -: SMP_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        samples[k*OUT_W +: OUT_W] <= '0;
      end else if (done) begin
        samples[k*OUT_W +: OUT_W] <= {{EXT_W{raw[SMP_W-1]}}, raw};
      end
    end

    // R5: upper bits always copy the sample's sign bit
    p_sign_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
      samples[k*OUT_W +: OUT_W] ==
        {{EXT_W{samples[k*OUT_W+SMP_W-1]}}, samples[k*OUT_W +: SMP_W]});
  end

  // R7: strobe lasts a single system clock
  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);
  // R7: parsed fields hold between strobes
  p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(lead_p) && $stable(lead_n) && $stable(gpio));
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_frame_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SMP_W       = 24,
  parameter int OUT_W       = 32,
  parameter int GPIO_W      = 4,
  parameter int DIV_W       = 8,
  parameter int OVR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     sclk_half,
  input  logic                 drdy_n,
  input  logic                 miso,
  output logic                 sclk,
  output logic                 cs_n,
  output logic                 frame_valid,
  output logic                 hdr_err,
  output logic [NCH-1:0]       lead_p,
  output logic [NCH-1:0]       lead_n,
  output logic [GPIO_W-1:0]    gpio,
  output logic [NCH*OUT_W-1:0] samples,
  output logic [OVR_W-1:0]     overrun_cnt
);
  localparam int STAT_W  = HDR_W + 2 * NCH + GPIO_W;
  localparam int FRAME_W = STAT_W + NCH * SMP_W;

  logic               start;
  logic               done;
  logic [FRAME_W-1:0] frame;

  afr_drdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .drdy_n (drdy_n),
    .fall   (start)
  );

  afr_shift_engine #(.FRAME_W(FRAME_W), .DIV_W(DIV_W), .OVR_W(OVR_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sclk_half (sclk_half),
    .miso      (miso),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .frame     (frame),
    .done      (done),
    .ovr_cnt   (overrun_cnt)
  );

  afr_frame_parser #(.NCH(NCH), .SMP_W(SMP_W), .OUT_W(OUT_W), .GPIO_W(GPIO_W)) u_parse (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .frame       (frame),
    .frame_valid (frame_valid),
    .hdr_err     (hdr_err),
    .lead_p      (lead_p),
    .lead_n      (lead_n),
    .gpio        (gpio),
    .samples     (samples)
  );

  // R1: a frame strobe follows chip select being released
  p_valid_after_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> cs_n);
endmodule

// File: tb/adc_frame_reader_tb_top.sv
module adc_frame_reader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   sclk_half = 8'd1;
  logic         drdy_n = 1'b1;
  logic         miso;
  logic         sclk, cs_n, frame_valid, hdr_err;
  logic [7:0]   lead_p, lead_n, overrun_cnt;
  logic [3:0]   gpio;
  logic [255:0] samples;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int fall_cnt = 0;
  int vcnt     = 0;
  int cs_low   = 0;
  int rise_idx = 0;
  logic [215:0] frame_cur = '0;
  logic fire = 1'b0;
  logic [23:0] chv [8];
  logic [23:0] spec [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_reader dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_half(sclk_half), .drdy_n(drdy_n), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .frame_valid(frame_valid), .hdr_err(hdr_err),
    .lead_p(lead_p), .lead_n(lead_n), .gpio(gpio), .samples(samples),
    .overrun_cnt(overrun_cnt)
  );

  // converter model: shifts on rising sclk, data-ready released on falling sclk
  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) rise_idx <= 0;
    else      rise_idx <= rise_idx + 1;
  end
  assign miso = (rise_idx == 0 || rise_idx > 216) ? 1'b0 : frame_cur[216 - rise_idx];

  always @(negedge sclk or posedge fire) begin
    if (fire) drdy_n <= 1'b0;
    else      drdy_n <= 1'b1;
  end

  always @(negedge sclk) fall_cnt++;
  always @(negedge clk) begin
    if (frame_valid) vcnt++;
    if (!cs_n) cs_low++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic do_frame(input int half, input logic [3:0] hd, input logic [7:0] lp,
                          input logic [7:0] ln, input logic [3:0] gp, input bit inject);
    int f0, v0, c0, eff;
    logic [215:0] f;
    eff = (half == 0) ? 1 : half;
    f = '0;
    f[215:192] = {hd, lp, ln, gp};
    for (int c = 0; c < 8; c++) f[191 - 24*c -: 24] = chv[c];
    sclk_half = 8'(half);
    frame_cur = f;
    @(negedge clk);
    f0 = fall_cnt; v0 = vcnt; c0 = cs_low;
    fire = 1'b1;
    @(negedge clk);
    fire = 1'b0;
    if (inject) begin
      @(negedge sclk);
      repeat (2) @(negedge clk);
      fire = 1'b1;
      @(negedge clk);
      fire = 1'b0;
    end
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (frame_valid) break;
    end
    check("R7 valid", 64'(frame_valid), 64'd1);
    check("R4 hdr_err", 64'(hdr_err), 64'(hd != 4'b1100));
    check("R3 lead_p", 64'(lead_p), 64'(lp));
    check("R3 lead_n", 64'(lead_n), 64'(ln));
    check("R3 gpio", 64'(gpio), 64'(gp));
    for (int c = 0; c < 8; c++)
      check("R5 sample", 64'(samples[32*c +: 32]), 64'({{8{chv[c][23]}}, chv[c]}));
    repeat (4) @(negedge clk);
    check("R7 one strobe", 64'(vcnt - v0), 64'd1);
    check("R3 lead_p held R7", 64'(lead_p), 64'(lp));
    check("R1 sclk periods", 64'(fall_cnt - f0), 64'd216);
    check("R2 cs low span", 64'(cs_low - c0), 64'(432 * eff));
    check("R1 cs released", 64'(cs_n), 64'd1);
  endtask

  initial begin
    spec[0] = 24'h800000; spec[1] = 24'hFFFFFF; spec[2] = 24'h7FFFFF; spec[3] = 24'h000000;
    spec[4] = 24'h000001; spec[5] = 24'h123456; spec[6] = 24'hABCDEF; spec[7] = 24'h400000;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 cs_n", 64'(cs_n), 64'd1);
    check("R8 sclk", 64'(sclk), 64'd0);
    check("R8 valid", 64'(frame_valid), 64'd0);
    check("R8 hdr_err", 64'(hdr_err), 64'd0);
    check("R8 overrun", 64'(overrun_cnt), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // sweep divide ratios and rotate extreme sample codes through all channels
    for (int h = 0; h <= 4; h++) begin
      for (int r = 0; r < 2; r++) begin
        for (int c = 0; c < 8; c++) chv[c] = spec[(c + 3*h + r) % 8];
        do_frame(h, 4'b1100, 8'(8'hA5 ^ (h*17 + r)), 8'(8'h3C + h*r), 4'(h + 9*r), 1'b0);
      end
    end
    // R4: corrupted header still yields a frame
    for (int c = 0; c < 8; c++) chv[c] = 24'(c * 24'h111111);
    do_frame(2, 4'b1010, 8'hFF, 8'h00, 4'hF, 1'b0);
    do_frame(1, 4'b0100, 8'h01, 8'h80, 4'h8, 1'b0);
    // R6: mid-frame data-ready fall is counted and does not disturb the frame
    for (int c = 0; c < 8; c++) chv[c] = spec[7 - c];
    do_frame(8, 4'b1100, 8'h5A, 8'hC3, 4'h6, 1'b1);
    check("R6 overrun count", 64'(overrun_cnt), 64'd1);
    begin
      int v1;
      v1 = vcnt;
      repeat (500) @(negedge clk);
      check("R6 no restart", 64'(vcnt - v1), 64'd0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule